// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides, row by row, whether a DRAM row needs a refresh command in the current refresh round. Most rows keep their charge much longer than the worst-case interval. Rows that hold weak cells are recorded in two small membership filters, and only those rows are refreshed at the fast rates. Each filter is a Bloom filter, so it costs little storage. A false positive only adds refreshes and never drops one. A retention profiler, outside this block, loads the filters through an insert port. After that, a periodic tick walks the row space one row at a time.

Each filter is a bit array indexed by several XOR-fold hashes of the row address. The fast filter (bin 0) sends its rows to a refresh every 64 ms round. The middle filter (bin 1) sends its rows every second round. Every other row is refreshed once every fourth round, which is 256 ms. A row that hits both filters takes the fast rate. A clear input empties both filters. While the filters hold nothing and a safe-mode input is high, every row is treated as fast, so a fresh or cleared controller never under-refreshes.

Top module: `rbr_refresh_ctrl`

## Requirements
- R1: While reset is high, `ref_valid_o` is 0. After reset, the row pointer and the round counter start at 0.
- R2: Each cycle with `tick_i` high processes exactly one row. Rows are processed in ascending order and wrap from 2^ROW_W-1 to 0. `ref_valid_o` can be high only in the cycle that follows a tick.
- R3: The round counter counts modulo 4. It advances in the tick that processes row 2^ROW_W-1.
- R4: A row that hits bin 0 is refreshed in every round, which gives 4 refreshes in any 4 consecutive rounds.
- R5: A row that hits bin 1 but not bin 0 is refreshed only in even rounds (0 and 2), which gives 2 refreshes per 4 rounds.
- R6: A row that hits neither bin is refreshed only in round 0, which gives 1 refresh per 4 rounds.
- R7: A row that hits both bins takes the bin 0 rate.
- R8: Hash j, for j from 0 to NUM_HASH-1, is computed as follows. Take v = row XOR (row >> (j+1)). For each bit b of v, XOR v[b] into index bit (b mod FILT_W). An insert with `ins_bin_i` = 0 (bin 0) or 1 (bin 1) sets all NUM_HASH indexed bits of that bin. A query hits only when all of those bits are set. An insert counts for ticks from the next cycle on.
- R9: `bin_clear_i` empties both filters. An insert in the same cycle as a clear has no effect.
- R10: While `safe_mode_i` is high, and no insert has taken effect since reset or the last clear, every row is refreshed in every round.
- R11: When `ref_valid_o` is high, `ref_row_o` holds the row processed by the preceding tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base tick: process the next row |
| ins_valid_i | input | 1 | Insert a row into a bin |
| ins_bin_i | input | 1 | Target bin of the insert (0 fast, 1 middle) |
| ins_row_i | input | ROW_W | Row address to insert |
| bin_clear_i | input | 1 | Clear all filter bits |
| safe_mode_i | input | 1 | Refresh all rows at the fast rate while the filters are empty |
| ref_valid_o | output | 1 | Refresh command valid |
| ref_row_o | output | ROW_W | Row address of the refresh command |

## Verification
The bench builds the block with ROW_W=6, FILT_W=5 and NUM_HASH=2. A whole 256 ms window therefore takes only 256 ticks, so the bench can count refreshes per row over several full windows. The 32-bit filters are small enough that random inserts produce real false positives and rows that hit both bins. These exercise the priority rule and the check that the refresh count never falls below the row's class rate.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    localparam int NUM_BINS  = 2;
    localparam int BIN_SEL_W = $clog2(NUM_BINS);
    localparam int ROUND_W   = 2;

    // refresh class of a row: 64 ms, 128 ms, 256 ms
    typedef enum logic [1:0] {
        CLS_FAST = 2'd0,
        CLS_MID  = 2'd1,
        CLS_SLOW = 2'd2
    } rclass_t;

    typedef struct packed {
        logic    hit0;
        logic    hit1;
        logic    safe;
    } cls_in_t;

    function automatic rclass_t bin_class(input int b);
        return (b == 0) ? CLS_FAST : CLS_MID;
    endfunction

    function automatic logic rbr_due(input rclass_t c, input logic [ROUND_W-1:0] round);
        case (c)
            CLS_FAST: return 1'b1;
            CLS_MID:  return (round[0] == 1'b0);
            default:  return (round == '0);
        endcase
    endfunction

endpackage

// File: rtl/rbr_bloom_bin.sv
module rbr_bloom_bin #(
    parameter int ROW_W    = 12,
    parameter int FILT_W   = 8,
    parameter int NUM_HASH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             ins_i,
    input  logic [ROW_W-1:0] ins_row_i,
    input  logic [ROW_W-1:0] qry_row_i,
    output logic             hit_o
);
    localparam int FILT_SZ = 1 << FILT_W;

    logic [FILT_SZ-1:0] bits_q;
    logic [FILT_SZ-1:0] set_mask;
    logic [NUM_HASH-1:0] probe;

    function automatic logic [FILT_W-1:0] fold_hash(input logic [ROW_W-1:0] r, input int j);
        logic [ROW_W-1:0]  v;
        logic [FILT_W-1:0] h;
        v = r ^ (r >> (j + 1));
        h = '0;
        for (int b = 0; b < ROW_W; b++) begin
            h[b % FILT_W] = h[b % FILT_W] ^ v[b];
        end
        return h;
    endfunction

    always_comb begin
        set_mask = '0;
        for (int j = 0; j < NUM_HASH; j++) begin
            set_mask[fold_hash(ins_row_i, j)] = 1'b1;
        end
    end

    for (genvar j = 0; j < NUM_HASH; j++) begin : g_probe
        assign probe[j] = bits_q[fold_hash(qry_row_i, j)];
    end

    assign hit_o = &probe;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            bits_q <= '0;
        end else if (ins_i) begin
            bits_q <= bits_q | set_mask;
        end
    end

endmodule

// File: rtl/rbr_sweep.sv
module rbr_sweep #(
    parameter int ROW_W   = 12,
    parameter int ROUND_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    output logic [ROW_W-1:0]   row_o,
    output logic [ROUND_W-1:0] round_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = {ROW_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            row_o   <= '0;
            round_o <= '0;
        end else if (tick_i) begin
            row_o <= row_o + 1'b1;
            if (row_o == LAST_ROW) begin
                round_o <= round_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rbr_classify.sv
module rbr_classify
    import rbr_pkg::*;
(
    input  logic [NUM_BINS-1:0] hit_i,
    input  logic                safe_i,
    output rclass_t             cls_o
);
    always_comb begin
        cls_o = CLS_SLOW;
        // lowest bin index wins: shortest interval
        for (int b = NUM_BINS - 1; b >= 0; b--) begin
            if (hit_i[b]) begin
                cls_o = bin_class(b);
            end
        end
        if (safe_i) begin
            cls_o = CLS_FAST;
        end
    end

endmodule

// File: rtl/rbr_refresh_ctrl.sv
module rbr_refresh_ctrl
    import rbr_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int FILT_W   = 8,
    parameter int NUM_HASH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 ins_valid_i,
    input  logic [BIN_SEL_W-1:0] ins_bin_i,
    input  logic [ROW_W-1:0]     ins_row_i,
    input  logic                 bin_clear_i,
    input  logic                 safe_mode_i,
    output logic                 ref_valid_o,
    output logic [ROW_W-1:0]     ref_row_o
);
    logic [ROW_W-1:0]    row_q;
    logic [ROUND_W-1:0]  round_q;
    logic [NUM_BINS-1:0] hit;
    logic                any_ins_q;
    rclass_t             cls;

    rbr_sweep #(.ROW_W(ROW_W), .ROUND_W(ROUND_W)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .row_o   (row_q),
        .round_o (round_q)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        logic ins_here;
        assign ins_here = ins_valid_i && !bin_clear_i && (ins_bin_i == b[BIN_SEL_W-1:0]);
        rbr_bloom_bin #(.ROW_W(ROW_W), .FILT_W(FILT_W), .NUM_HASH(NUM_HASH)) u_bin (
            .clk       (clk),
            .rst       (rst),
            .clr_i     (bin_clear_i),
            .ins_i     (ins_here),
            .ins_row_i (ins_row_i),
            .qry_row_i (row_q),
            .hit_o     (hit[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || bin_clear_i) begin
            any_ins_q <= 1'b0;
        end else if (ins_valid_i) begin
            any_ins_q <= 1'b1;
        end
    end

    rbr_classify u_cls (
        .hit_i  (hit),
        .safe_i (safe_mode_i && !any_ins_q),
        .cls_o  (cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_valid_o <= 1'b0;
            ref_row_o   <= '0;
        end else begin
            ref_valid_o <= tick_i && rbr_due(cls, round_q);
            if (tick_i) begin
                ref_row_o <= row_q;
            end
        end
    end

endmodule

// File: rtl/rbr_refresh_sva.sv
module rbr_refresh_sva
    import rbr_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_i,
    input logic               bin_clear_i,
    input logic               safe_mode_i,
    input logic               ref_valid_o,
    input logic [ROW_W-1:0]   ref_row_o,
    input logic [ROW_W-1:0]   row_q,
    input logic [ROUND_W-1:0] round_q,
    input rclass_t            cls,
    input logic               any_ins_q
);
    assert_valid_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
        ref_valid_o |-> $past(tick_i));

    assert_row_advance_R2: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> row_q == $past(row_q) + 1'b1);

    assert_cmd_row_R11: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> ref_row_o == $past(row_q));

    assert_round_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && row_q == {ROW_W{1'b1}}) |=> round_q == $past(round_q) + 1'b1);

    assert_round_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick_i) |=> $stable(round_q));

    assert_fast_due_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cls == CLS_FAST) |=> ref_valid_o);

    assert_slow_skip_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cls == CLS_SLOW && round_q != '0) |=> !ref_valid_o);

    assert_mid_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cls == CLS_MID && round_q[0]) |=> !ref_valid_o);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
        bin_clear_i |=> !any_ins_q);

    assert_safe_fast_R10: assert property (@(posedge clk) disable iff (rst)
        (safe_mode_i && !any_ins_q) |-> cls == CLS_FAST);

endmodule

bind rbr_refresh_ctrl rbr_refresh_sva #(.ROW_W(ROW_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .bin_clear_i (bin_clear_i),
    .safe_mode_i (safe_mode_i),
    .ref_valid_o (ref_valid_o),
    .ref_row_o   (ref_row_o),
    .row_q       (row_q),
    .round_q     (round_q),
    .cls         (cls),
    .any_ins_q   (any_ins_q)
);

// File: tb/rbr_refresh_ctrl_test.sv
module rbr_refresh_ctrl_test;
    localparam int RW    = 6;
    localparam int FW    = 5;
    localparam int NH    = 2;
    localparam int NROWS = 1 << RW;
    localparam int FSZ   = 1 << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic          ins_valid_i = 1'b0;
    logic [0:0]    ins_bin_i = 1'b0;
    logic [RW-1:0] ins_row_i = '0;
    logic          bin_clear_i = 1'b0;
    logic          safe_mode_i = 1'b0;
    logic          ref_valid_o;
    logic [RW-1:0] ref_row_o;

    always #2 clk = ~clk;

    rbr_refresh_ctrl #(.ROW_W(RW), .FILT_W(FW), .NUM_HASH(NH)) uut (
        .clk, .rst, .tick_i, .ins_valid_i, .ins_bin_i, .ins_row_i,
        .bin_clear_i, .safe_mode_i, .ref_valid_o, .ref_row_o
    );

    int checks = 0;
    int failures = 0;
    logic [FSZ-1:0] mbits [2];
    bit  m_any = 0;
    int  m_row = 0;
    int  m_round = 0;
    int  cnt [NROWS];

    function automatic int m_hash(input int r, input int j);
        logic [RW-1:0] rr, v;
        logic [FW-1:0] h;
        rr = r[RW-1:0];
        v  = rr ^ (rr >> (j + 1));
        h  = '0;
        for (int b = 0; b < RW; b++) h[b % FW] = h[b % FW] ^ v[b];
        return int'(h);
    endfunction

    function automatic bit m_hit(input int bn, input int r);
        bit ok = 1;
        for (int j = 0; j < NH; j++) if (!mbits[bn][m_hash(r, j)]) ok = 0;
        return ok;
    endfunction

    function automatic int m_class(input int r);
        if (safe_mode_i && !m_any) return 0;
        if (m_hit(0, r)) return 0;
        if (m_hit(1, r)) return 1;
        return 2;
    endfunction

    function automatic bit m_due(input int c, input int rnd);
        return (c == 0) || (c == 1 && rnd % 2 == 0) || (c == 2 && rnd == 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        int  c;
        bit  ev;
        c  = m_class(m_row);
        ev = m_due(c, m_round);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        // class R4/R5/R6/R10 decides due; R3 round tracking
        check(ref_valid_o == ev, (c == 0) ? "R4" : (c == 1) ? "R5" : "R6",
              int'(ref_valid_o), int'(ev));
        if (ref_valid_o) begin
            check(int'(ref_row_o) == m_row, "R11", int'(ref_row_o), m_row);
            cnt[int'(ref_row_o)]++;
        end
        if (m_row == NROWS - 1) m_round = (m_round + 1) % 4;
        m_row = (m_row + 1) % NROWS;
    endtask

    task automatic do_insert(input int bn, input int r);
        @(negedge clk);
        ins_valid_i = 1'b1;
        ins_bin_i   = bn[0:0];
        ins_row_i   = r[RW-1:0];
        @(negedge clk);
        ins_valid_i = 1'b0;
        for (int j = 0; j < NH; j++) mbits[bn][m_hash(r, j)] = 1'b1;
        m_any = 1;
    endtask

    task automatic do_clear(input bit with_ins);
        @(negedge clk);
        bin_clear_i = 1'b1;
        ins_valid_i = with_ins;
        ins_bin_i   = 1'b0;
        ins_row_i   = 6'd5;
        @(negedge clk);
        bin_clear_i = 1'b0;
        ins_valid_i = 1'b0;
        mbits[0] = '0;
        mbits[1] = '0;
        m_any = 0;
    endtask

    // full 256 ms window starting at round 0, row 0
    task automatic run_window(input string tag, input bit gaps);
        int exp;
        for (int r = 0; r < NROWS; r++) cnt[r] = 0;
        for (int t = 0; t < 4 * NROWS; t++) begin
            do_tick();
            if (gaps && ($urandom % 4 == 0)) begin
                repeat (1 + $urandom % 3) begin
                    @(negedge clk);
                    check(ref_valid_o == 1'b0, "R2", int'(ref_valid_o), 0);
                end
            end
        end
        for (int r = 0; r < NROWS; r++) begin
            exp = 4 >> m_class(r);
            if (m_class(r) == 2) exp = 1;
            check(cnt[r] == exp, tag, cnt[r], exp);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0447);
        mbits[0] = '0;
        mbits[1] = '0;
        repeat (3) @(negedge clk);
        check(ref_valid_o == 1'b0, "R1", int'(ref_valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ref_valid_o == 1'b0, "R1", int'(ref_valid_o), 0);

        // safe mode with empty filters: every row every round
        safe_mode_i = 1'b1;
        run_window("R10", 1'b0);
        check(m_round == 0 && m_row == 0, "R3", m_round, 0);

        // idle: no command without tick
        repeat (5) begin
            @(negedge clk);
            check(ref_valid_o == 1'b0, "R2", int'(ref_valid_o), 0);
        end

        // directed bins: row 7 fast, row 20 mid, row 33 in both
        do_insert(0, 7);
        do_insert(1, 20);
        do_insert(1, 33);
        do_insert(0, 33);
        check(m_class(33) == 0, "R7", m_class(33), 0);
        run_window("R8", 1'b0);
        check(cnt[7] == 4, "R4", cnt[7], 4);
        check(cnt[33] == 4, "R7", cnt[33], 4);
        check(cnt[20] >= 2, "R5", cnt[20], 2);

        // clear with simultaneous insert, safe mode off: all slow
        safe_mode_i = 1'b0;
        do_clear(1'b1);
        run_window("R9", 1'b0);
        check(cnt[5] == 1, "R9", cnt[5], 1);

        // safe mode again after clear: all fast until insert
        safe_mode_i = 1'b1;
        run_window("R10", 1'b0);
        do_insert(1, 12);
        run_window("R6", 1'b1);

        // random fills with gaps
        for (int it = 0; it < 3; it++) begin
            do_clear(1'b0);
            safe_mode_i = ($urandom % 2) == 1;
            repeat (3 + $urandom % 6) do_insert($urandom % 2, $urandom % NROWS);
            run_window("R5", 1'b1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule